// File: doc/BRIEF.md
# Load-Use Stall and Operand Forwarding Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It watches the register fields of the instruction in decode, the load flag and target register of the instruction in execute, and the write flags and destination registers held in the two later pipeline registers.

It has two jobs. The first is to spot a load whose result the very next instruction needs. When it finds one, it freezes the program counter and the fetch/decode register for one cycle and zeroes the control bits entering execute, so that a bubble is inserted. After that bubble the loaded value reaches the consumer through the writeback bypass.

The second job is to choose, for each of the two ALU operands in execute, one of three sources: the register file, the memory-stage result, or the writeback-stage value. When both later stages match, the younger memory-stage result wins.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: A stall (pc_we=0) can only occur while ex_mem_read=1; with ex_mem_read=0 the outputs are pc_we=1, ifid_we=1, ctrl_zero=0 whatever the other inputs.
- R2: With ex_mem_read=1, ex_rt nonzero and ex_rt equal to id_rs, a stall is raised, for every opcode.
- R3: With ex_mem_read=1, ex_rt nonzero and ex_rt equal to id_rt, a stall is raised only when the decode opcode reads rt: opcode 0 (register-register), 4 and 5 (compare-and-branch) and 40 to 47 (stores). Any other opcode (loads, immediate ALU, jumps) ignores the rt match.
- R4: The three stall outputs always move together: during a stall pc_we=0, ifid_we=0 and ctrl_zero=1; otherwise pc_we=1, ifid_we=1 and ctrl_zero=0.
- R5: An operand select of 2 (binary 10) is produced when exmem_reg_write=1, exmem_rd is nonzero and exmem_rd equals the operand's register number.
- R6: An operand select of 1 (binary 01) is produced when memwb_reg_write=1, memwb_rd is nonzero, memwb_rd equals the operand's register number, and the memory stage does not match as in R5.
- R7: When the memory stage and the writeback stage both match the same operand, the select is 2.
- R8: Register 0 never causes forwarding or a stall, even when every write flag is set and every register field is 0.
- R9: With no qualifying match the select is 0 (register file); the code 3 is never produced.
- R10: Operand A (fwd_a, register ex_rs) and operand B (fwd_b, register ex_rt) are selected independently under the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second register field of the instruction in decode |
| ex_mem_read | input | 1 | Instruction in execute reads data memory (is a load) |
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second register field in execute; the load target |
| exmem_reg_write | input | 1 | Memory-stage instruction writes a register |
| exmem_rd | input | 5 | Destination register of the memory-stage instruction |
| memwb_reg_write | input | 1 | Writeback-stage instruction writes a register |
| memwb_rd | input | 5 | Destination register of the writeback-stage instruction |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| ctrl_zero | output | 1 | Clear the control bits passed into execute |
| fwd_a | output | 2 | Source select for operand A |
| fwd_b | output | 2 | Source select for operand B |

## Verification
The hardest cases to reach from the ports are the coincidences. One is a load whose target equals the decode rt field while the opcode belongs to exactly one of the rt-reading or rt-writing classes. Another is both later stages naming the same operand register at once, including register 0. Uniform random values almost never line up five-bit fields, so the stimulus draws every register number from 0 to 3 and takes the decode opcode from a short list covering each opcode class. Directed vectors replay the classic dependent-add and load-then-use sequences before the random run.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OP_W = 6;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_sel_e;

  // Opcode classes whose second register field is read, not written.
  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE   = 6'd5;
  localparam logic [2:0]      OP_STORE_GRP = 3'b101;

  function automatic logic rt_is_source(input logic [OP_W-1:0] op);
    return (op == OP_RTYPE) || (op == OP_BEQ) || (op == OP_BNE) ||
           (op[OP_W-1:OP_W-3] == OP_STORE_GRP);
  endfunction

  // Newer stage first: memory stage beats writeback.
  function automatic fwd_sel_e pick_src(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SRC_MEM;
    else if (wb_hit) return SRC_WB;
    else             return SRC_RF;
  endfunction
endpackage

// File: rtl/load_use_detect.sv
module load_use_detect
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [OP_W-1:0]  dec_op,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic             exe_is_load,
  input  logic [REG_W-1:0] exe_target,
  output logic             rs_hit,
  output logic             rt_hit,
  output logic             stall
);
  logic target_live;

  assign target_live = exe_is_load && (exe_target != '0);
  assign rs_hit      = target_live && (exe_target == dec_rs);
  assign rt_hit      = target_live && rt_is_source(dec_op) && (exe_target == dec_rt);
  assign stall       = rs_hit || rt_hit;
endmodule

// File: rtl/operand_fwd_sel.sv
module operand_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_reg,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic             mem_hit,
  output logic             wb_hit,
  output fwd_sel_e         sel
);
  logic src_live;

  assign src_live = (src_reg != '0);
  assign mem_hit  = src_live && mem_wen && (mem_dst == src_reg);
  assign wb_hit   = src_live && wb_wen  && (wb_dst  == src_reg);
  assign sel      = pick_src(mem_hit, wb_hit);
endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int N_OPND = 2
) (
  input  logic [5:0]       id_opcode,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic             exmem_reg_write,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             memwb_reg_write,
  input  logic [REG_W-1:0] memwb_rd,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ctrl_zero,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b
);
  // Named internal events, visible to the bound checker.
  logic             load_stall;
  logic             stall_rs_hit;
  logic             stall_rt_hit;
  logic [REG_W-1:0] opnd_reg [N_OPND];
  fwd_sel_e         opnd_sel [N_OPND];
  logic [N_OPND-1:0] opnd_mem_hit;
  logic [N_OPND-1:0] opnd_wb_hit;

  load_use_detect #(.REG_W(REG_W)) u_detect (
    .dec_op      (id_opcode),
    .dec_rs      (id_rs),
    .dec_rt      (id_rt),
    .exe_is_load (ex_mem_read),
    .exe_target  (ex_rt),
    .rs_hit      (stall_rs_hit),
    .rt_hit      (stall_rt_hit),
    .stall       (load_stall)
  );

  assign opnd_reg[0] = ex_rs;
  assign opnd_reg[1] = ex_rt;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    operand_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src_reg (opnd_reg[g]),
      .mem_wen (exmem_reg_write),
      .mem_dst (exmem_rd),
      .wb_wen  (memwb_reg_write),
      .wb_dst  (memwb_rd),
      .mem_hit (opnd_mem_hit[g]),
      .wb_hit  (opnd_wb_hit[g]),
      .sel     (opnd_sel[g])
    );
  end

  assign pc_we     = !load_stall;
  assign ifid_we   = !load_stall;
  assign ctrl_zero = load_stall;
  assign fwd_a     = opnd_sel[0];
  assign fwd_b     = opnd_sel[1];
endmodule

// File: rtl/hazard_fwd_ctrl_chk.sv
module hazard_fwd_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic [5:0]       id_opcode,
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] id_rt,
  input logic             ex_mem_read,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] ex_rt,
  input logic             exmem_reg_write,
  input logic [REG_W-1:0] exmem_rd,
  input logic             memwb_reg_write,
  input logic [REG_W-1:0] memwb_rd,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             ctrl_zero,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             stall_rs_hit,
  input logic             stall_rt_hit
);
  always_comb begin
    if (!ex_mem_read)
      assert_no_stall_without_load_R1: assert (pc_we && !stall_rs_hit && !stall_rt_hit);
    if (ex_mem_read && ex_rt != '0 && ex_rt == id_rs)
      assert_rs_dependency_stalls_R2: assert (!pc_we);
    if (stall_rt_hit)
      assert_rt_hit_needs_match_R3: assert (ex_rt == id_rt && ex_rt != '0);
    assert_stall_outputs_agree_R4: assert (pc_we == ifid_we && ctrl_zero == !pc_we);
    if (fwd_a == 2'b10)
      assert_mem_fwd_needs_write_R5: assert (exmem_reg_write && exmem_rd == ex_rs);
    if (fwd_b == 2'b01)
      assert_wb_fwd_needs_write_R6: assert (memwb_reg_write && memwb_rd == ex_rt);
    if (exmem_reg_write && exmem_rd != '0 && exmem_rd == ex_rs)
      assert_mem_wins_R7: assert (fwd_a == 2'b10);
    if (ex_rs == '0)
      assert_reg0_no_fwd_R8: assert (fwd_a == 2'b00);
    assert_no_code3_R9: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
  end
endmodule

bind hazard_fwd_ctrl hazard_fwd_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .id_opcode       (id_opcode),
  .id_rs           (id_rs),
  .id_rt           (id_rt),
  .ex_mem_read     (ex_mem_read),
  .ex_rs           (ex_rs),
  .ex_rt           (ex_rt),
  .exmem_reg_write (exmem_reg_write),
  .exmem_rd        (exmem_rd),
  .memwb_reg_write (memwb_reg_write),
  .memwb_rd        (memwb_rd),
  .pc_we           (pc_we),
  .ifid_we         (ifid_we),
  .ctrl_zero       (ctrl_zero),
  .fwd_a           (fwd_a),
  .fwd_b           (fwd_b),
  .stall_rs_hit    (stall_rs_hit),
  .stall_rt_hit    (stall_rt_hit)
);

// File: tb/sim_hazard_fwd_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_fwd_ctrl;
  logic       clk = 0;
  logic [5:0] id_opcode;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, exmem_rd, memwb_rd;
  logic       ex_mem_read, exmem_reg_write, memwb_reg_write;
  logic       pc_we, ifid_we, ctrl_zero;
  logic [1:0] fwd_a, fwd_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Opcodes covering each class: rt read (0,4,5,40,41,43) and rt written/unused.
  int op_pool[$] = '{0, 4, 5, 40, 41, 43, 35, 32, 8, 13, 15, 2};

  always #10 clk = ~clk;  // 50 MHz

  hazard_fwd_ctrl u0 (
    .id_opcode(id_opcode), .id_rs(id_rs), .id_rt(id_rt),
    .ex_mem_read(ex_mem_read), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .exmem_reg_write(exmem_reg_write), .exmem_rd(exmem_rd),
    .memwb_reg_write(memwb_reg_write), .memwb_rd(memwb_rd),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  function automatic bit m_reads_rt(int op);
    foreach (op_pool[i]) ;
    case (op)
      0, 4, 5, 40, 41, 42, 43, 44, 45, 46, 47: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_stall();
    int tgt = int'(ex_rt);
    if (!ex_mem_read || tgt == 0) return 0;
    if (tgt == int'(id_rs)) return 1;
    return m_reads_rt(int'(id_opcode)) && tgt == int'(id_rt);
  endfunction

  function automatic int m_src(int r);
    if (r == 0) return 0;
    if (exmem_reg_write && int'(exmem_rd) == r) return 2;
    if (memwb_reg_write && int'(memwb_rd) == r) return 1;
    return 0;
  endfunction

  function automatic string tag_src(int r, string opnd_tag);
    if (r == 0) return "R8";
    if (exmem_reg_write && int'(exmem_rd) == r && memwb_reg_write && int'(memwb_rd) == r) return "R7";
    if (exmem_reg_write && int'(exmem_rd) == r) return "R5";
    if (memwb_reg_write && int'(memwb_rd) == r) return "R6";
    return (opnd_tag == "") ? "R9" : opnd_tag;
  endfunction

  task automatic compare_all(string note);
    bit s = m_stall();
    int ea = m_src(int'(ex_rs));
    int eb = m_src(int'(ex_rt));
    string st = !ex_mem_read ? "R1" : (int'(ex_rt) != 0 && ex_rt == id_rs) ? "R2" : "R3";
    string ta = tag_src(int'(ex_rs), "");
    string tb = tag_src(int'(ex_rt), "R10");
    n_vec++;
    if (pc_we !== !s || ifid_we !== !s || ctrl_zero !== s) begin
      n_bad++;
      $display("FAIL %s R4 %s: pc_we=%0b ifid_we=%0b ctrl_zero=%0b expected stall=%0b",
               st, note, pc_we, ifid_we, ctrl_zero, s);
    end
    n_vec++;
    if (int'(fwd_a) != ea) begin
      n_bad++;
      $display("FAIL %s %s: fwd_a=%0d expected %0d", ta, note, fwd_a, ea);
    end
    n_vec++;
    if (int'(fwd_b) != eb) begin
      n_bad++;
      $display("FAIL %s R10 %s: fwd_b=%0d expected %0d", tb, note, fwd_b, eb);
    end
  endtask

  task automatic apply(int op, int irs, int irt, bit ld, int ers, int ert,
                       bit mw, int mrd, bit ww, int wrd, string note);
    @(posedge clk);
    id_opcode = 6'(op); id_rs = 5'(irs); id_rt = 5'(irt);
    ex_mem_read = ld; ex_rs = 5'(ers); ex_rt = 5'(ert);
    exmem_reg_write = mw; exmem_rd = 5'(mrd);
    memwb_reg_write = ww; memwb_rd = 5'(wrd);
    @(negedge clk);
    compare_all(note);
  endtask

  initial begin
    id_opcode = 0; id_rs = 0; id_rt = 0; ex_mem_read = 0; ex_rs = 0; ex_rt = 0;
    exmem_reg_write = 0; exmem_rd = 0; memwb_reg_write = 0; memwb_rd = 0;
    @(negedge clk);
    compare_all("idle state R1 R9");
    // Dependent adds: operand B of the third add gets register 4 from memory stage (R5).
    apply(0, 3, 4, 0, 3, 4, 1, 4, 1, 2, "dependent add R5");
    // Register 2 written two back: writeback forward (R6) on operand A.
    apply(0, 2, 5, 0, 2, 4, 1, 4, 1, 2, "two-back add R6");
    // Both stages write register 4 (R7).
    apply(0, 0, 0, 0, 4, 4, 1, 4, 1, 4, "double match R7");
    // Register 0 everywhere with all writes set (R8).
    apply(0, 0, 0, 1, 0, 0, 1, 0, 1, 0, "reg0 R8");
    // Load-use on rs (R2), for an immediate opcode too.
    apply(0, 8, 9, 1, 1, 8, 0, 0, 0, 0, "load-use rs R2");
    apply(8, 8, 3, 1, 1, 8, 0, 0, 0, 0, "load-use rs addi R2");
    // rt match: store reads rt (R3), addi writes it (R3 ignored).
    apply(43, 1, 8, 1, 1, 8, 0, 0, 0, 0, "store rt R3");
    apply(8, 1, 8, 1, 1, 8, 0, 0, 0, 0, "addi rt ignored R3");
    apply(35, 1, 8, 1, 1, 8, 0, 0, 0, 0, "load rt ignored R3");
    apply(5, 2, 8, 1, 1, 8, 0, 0, 0, 0, "bne rt R3");
    // Same register match but no load in execute (R1).
    apply(0, 8, 8, 0, 1, 8, 0, 0, 0, 0, "no load R1");
    // Write flags clear: no forwarding (R9), operand B alone (R10).
    apply(0, 0, 0, 0, 6, 7, 0, 6, 0, 7, "no write R9");
    apply(0, 0, 0, 0, 6, 7, 1, 7, 0, 0, "operand B only R10");
    for (int k = 0; k < 3000; k++) begin
      apply(op_pool[$urandom_range(op_pool.size()-1)],
            $urandom_range(3), $urandom_range(3), 1'($urandom_range(1)),
            $urandom_range(3), $urandom_range(3),
            1'($urandom_range(1)), $urandom_range(3),
            1'($urandom_range(1)), $urandom_range(3), "random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule